// File: doc/BRIEF.md
# Serial Control Port Receiver

This block is the slave end of a three-wire control link: an enable line, a serial clock and a shared data line. While the enable is high the block samples the data line on every falling serial-clock edge, least significant bit first, and assembles one 16-bit frame. When the sixteenth edge arrives, an address field inside the frame selects one of two control registers, and the frame's upper data byte is written into that register. The block then pulls the data line low as an acknowledge until the enable is released.

The first control register holds two 4-bit gain codes, one for the tracking loop and one for the focus loop. The second holds a sleep bit and an offset-correction request bit. Every field returns to its default at reset and whenever the chip's offset-correction engine reports completion. While sleep is set, the gain codes are held at their default. Each gain code is also presented as a signed value in dB, for use by the analog control logic.

All three link inputs pass through a synchronizer into the system clock domain. The open-drain acknowledge is exported as a pull-low enable, which the pad cell uses.

Top module: `sctl_port`

## Requirements
- R1: Data is captured on falling serial-clock edges seen while the enable is high. The first captured bit becomes frame bit 0 and the sixteenth becomes bit 15.
- R2: If the enable falls after fewer than 16 falling edges, the frame is discarded. No register changes and no acknowledge is given.
- R3: If more than 16 falling edges occur, only the first 16 bits are used. The write happens at the sixteenth edge, and later bits change nothing.
- R4: After a sixteenth edge, `ack_pull_low` goes high and stays high until the enable goes low. At all other times it is low.
- R5: The address is frame bits 6..2. Value 0 selects the gain register and value 1 selects the mode register. Any other value writes nothing but is still acknowledged. Bits 7, 1 and 0 are ignored.
- R6: In the gain register, bits 15..12 carry the tracking gain code and bits 11..8 carry the focus gain code. Both codes reset to 4'b0111.
- R7: In the mode register, bit 15 is sleep and bit 14 is the correction request. Both reset to 0.
- R8: A pulse on `corr_done` restores all fields to their defaults.
- R9: While sleep is set, both gain outputs read 4'b0111 and writes to the gain register are ignored. After sleep is cleared, the gain codes stay at their default until they are rewritten.
- R10: `corr_req` is the stored request bit, masked while sleep is set.
- R11: Each gain code `c` is also output as the signed 6-bit value 14 − 2·c dB. Code 0 gives +14 and code 15 gives −16.
- R12: While the enable is low the frame state is cleared, so a frame that was cut short has no effect on the next one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_en | input | 1 | Link enable, high during a frame |
| ser_clk | input | 1 | Serial clock, sampled on its falling edge |
| ser_din | input | 1 | Level of the shared data line |
| corr_done | input | 1 | One-cycle pulse: offset correction has completed |
| ack_pull_low | output | 1 | Open-drain acknowledge, pulls the data line low |
| trk_gain | output | 4 | Tracking gain code |
| foc_gain | output | 4 | Focus gain code |
| sleep | output | 1 | Sleep request |
| corr_req | output | 1 | Offset correction request, masked by sleep |
| trk_gain_db | output | 6 | Tracking gain in dB, two's complement |
| foc_gain_db | output | 6 | Focus gain in dB, two's complement |

## Verification
A link edge reaches the receiver after the two synchronizer stages, which is the second system clock edge. The capture and the acknowledge follow at the third edge, a register write at the fourth, and the sleep-forced gain at the fifth. The bench holds each serial-clock phase for six system cycles. It samples the acknowledge and the register outputs eight cycles after the last serial edge, and it samples the released acknowledge eight cycles after the enable falls. Every result is therefore settled before it is read, and none is read later than the next stimulus.

// File: rtl/sctl_pkg.sv
package sctl_pkg;

   typedef enum logic [1:0] {
      SEL_GAIN = 2'd0,
      SEL_MODE = 2'd1,
      SEL_NONE = 2'd2
   } port_sel_e;

   function automatic port_sel_e sel_of(input int unsigned addr);
      if (addr == 0)      return SEL_GAIN;
      else if (addr == 1) return SEL_MODE;
      else                return SEL_NONE;
   endfunction

endpackage

// File: rtl/sctl_sync.sv
module sctl_sync #(
   parameter int          W       = 1,
   parameter int          STAGES  = 2,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   generate
      if (STAGES < 0) begin : g_bad
         $error("sctl_sync: STAGES must not be negative");
      end
      if (STAGES == 0) begin : g_pass
         assign q = d;
      end else begin : g_chain
         logic [STAGES-1:0][W-1:0] stg;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
            end else begin
               stg[0] <= d;
               for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
            end
         end
         assign q = stg[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/sctl_frame_rx.sv
module sctl_frame_rx #(
   parameter int FRAME_BITS = 16
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  en_s,
   input  logic                  sclk_s,
   input  logic                  din_s,
   output logic                  frame_stb,
   output logic [FRAME_BITS-1:0] frame_word,
   output logic                  ack_q
);

   localparam int CNT_W = $clog2(FRAME_BITS + 1);
   localparam int IDX_W = (FRAME_BITS > 1) ? $clog2(FRAME_BITS) : 1;
   localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(FRAME_BITS - 1);
   localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_BITS);

   generate
      if (FRAME_BITS < 2) begin : g_bad
         $error("sctl_frame_rx: FRAME_BITS too small");
      end
   endgenerate

   logic                  sclk_d;
   logic [CNT_W-1:0]      cnt;
   logic [FRAME_BITS-1:0] shreg;
   logic                  fall;

   assign fall = en_s & sclk_d & ~sclk_s;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sclk_d    <= 1'b0;
         cnt       <= '0;
         shreg     <= '0;
         frame_stb <= 1'b0;
         ack_q     <= 1'b0;
      end else begin
         sclk_d <= sclk_s;
         if (!en_s) begin
            cnt       <= '0;
            shreg     <= '0;
            frame_stb <= 1'b0;
            ack_q     <= 1'b0;
         end else begin
            frame_stb <= 1'b0;
            if (fall && (cnt < CNT_FULL)) begin
               shreg[cnt[IDX_W-1:0]] <= din_s;
               cnt <= cnt + 1'b1;
               if (cnt == CNT_LAST) begin
                  frame_stb <= 1'b1;
                  ack_q     <= 1'b1;
               end
            end
         end
      end
   end

   assign frame_word = shreg;

   AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= CNT_FULL); // R3
   AST_STB_ONLY_FULL: assert property (@(posedge clk) disable iff (!rst_n)
      frame_stb |-> (cnt == CNT_FULL)); // R2
   AST_ACK_NEEDS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ack_q) |-> (cnt == CNT_FULL)); // R4
   AST_ACK_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
      !en_s |=> (!ack_q && cnt == '0)); // R12
   AST_ACK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_q && en_s) |=> ack_q); // R4

endmodule

// File: rtl/sctl_port_regs.sv
module sctl_port_regs
   import sctl_pkg::*;
#(
   parameter int              FRAME_BITS = 16,
   parameter int              ADDR_LSB   = 2,
   parameter int              ADDR_W     = 5,
   parameter int              GAIN_W     = 4,
   parameter logic [GAIN_W-1:0] GAIN_DEF = 4'b0111
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  frame_stb,
   input  logic [FRAME_BITS-1:0] frame_word,
   input  logic                  corr_done,
   output logic [GAIN_W-1:0]     trk_gain,
   output logic [GAIN_W-1:0]     foc_gain,
   output logic                  sleep,
   output logic                  corr_req
);

   localparam int TRK_LSB   = FRAME_BITS - GAIN_W;
   localparam int FOC_LSB   = TRK_LSB - GAIN_W;
   localparam int SLEEP_BIT = FRAME_BITS - 1;
   localparam int CORR_BIT  = FRAME_BITS - 2;

   generate
      if (FOC_LSB < ADDR_LSB + ADDR_W) begin : g_bad
         $error("sctl_port_regs: gain fields overlap the address field");
      end
   endgenerate

   logic [ADDR_W-1:0] addr;
   port_sel_e         sel;
   logic [GAIN_W-1:0] trk_q, foc_q;
   logic              sleep_q, corr_q;
   logic              unused_word;

   assign addr = frame_word[ADDR_LSB +: ADDR_W];
   assign sel  = sel_of(int'(addr));
   assign unused_word = ^frame_word;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         trk_q   <= GAIN_DEF;
         foc_q   <= GAIN_DEF;
         sleep_q <= 1'b0;
         corr_q  <= 1'b0;
      end else if (corr_done) begin
         trk_q   <= GAIN_DEF;
         foc_q   <= GAIN_DEF;
         sleep_q <= 1'b0;
         corr_q  <= 1'b0;
      end else begin
         if (sleep_q) begin
            trk_q <= GAIN_DEF;
            foc_q <= GAIN_DEF;
         end else if (frame_stb && sel == SEL_GAIN) begin
            trk_q <= frame_word[TRK_LSB +: GAIN_W];
            foc_q <= frame_word[FOC_LSB +: GAIN_W];
         end
         if (frame_stb && sel == SEL_MODE) begin
            sleep_q <= frame_word[SLEEP_BIT];
            corr_q  <= frame_word[CORR_BIT];
         end
      end
   end

   assign trk_gain = sleep_q ? GAIN_DEF : trk_q;
   assign foc_gain = sleep_q ? GAIN_DEF : foc_q;
   assign sleep    = sleep_q;
   assign corr_req = corr_q & ~sleep_q;

   AST_CORR_RESTORE: assert property (@(posedge clk) disable iff (!rst_n)
      corr_done |=> (trk_q == GAIN_DEF && foc_q == GAIN_DEF && !sleep_q && !corr_q)); // R8
   AST_SLEEP_GAINS: assert property (@(posedge clk) disable iff (!rst_n)
      (sleep_q && $past(sleep_q)) |-> (trk_q == GAIN_DEF && foc_q == GAIN_DEF)); // R9
   AST_UNKNOWN_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_stb && sel == SEL_NONE && !corr_done && !sleep_q)
         |=> ($stable(trk_q) && $stable(foc_q) && $stable(sleep_q) && $stable(corr_q))); // R5
   AST_NO_WRITE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (!frame_stb && !corr_done && !sleep_q)
         |=> ($stable(trk_q) && $stable(foc_q) && $stable(sleep_q) && $stable(corr_q))); // R2

endmodule

// File: rtl/sctl_gain_map.sv
module sctl_gain_map #(
   parameter int GAIN_W  = 4,
   parameter int DB_W    = 6,
   parameter int DB_MAX  = 14,
   parameter int DB_STEP = 2
) (
   input  logic [GAIN_W-1:0]      code,
   output logic signed [DB_W-1:0] db
);

   localparam int DB_MIN = DB_MAX - DB_STEP * ((1 << GAIN_W) - 1);

   generate
      if (DB_MAX >= (1 << (DB_W - 1)) || DB_MIN < -(1 << (DB_W - 1))) begin : g_bad
         $error("sctl_gain_map: dB range does not fit DB_W");
      end
   endgenerate

   assign db = DB_W'(DB_MAX) - DB_W'(DB_STEP) * DB_W'(code);

endmodule

// File: rtl/sctl_port.sv
module sctl_port #(
   parameter int FRAME_BITS  = 16,
   parameter int SYNC_STAGES = 2,
   parameter int ADDR_LSB    = 2,
   parameter int ADDR_W      = 5,
   parameter int GAIN_W      = 4,
   parameter int GAIN_DEF    = 7,
   parameter int DB_W        = 6,
   parameter int DB_MAX      = 14,
   parameter int DB_STEP     = 2
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   ser_en,
   input  logic                   ser_clk,
   input  logic                   ser_din,
   input  logic                   corr_done,
   output logic                   ack_pull_low,
   output logic [GAIN_W-1:0]      trk_gain,
   output logic [GAIN_W-1:0]      foc_gain,
   output logic                   sleep,
   output logic                   corr_req,
   output logic signed [DB_W-1:0] trk_gain_db,
   output logic signed [DB_W-1:0] foc_gain_db
);

   localparam int N_GAINS = 2;
   localparam logic [GAIN_W-1:0] GAIN_DEF_V = GAIN_W'(GAIN_DEF);

   generate
      if (GAIN_DEF >= (1 << GAIN_W)) begin : g_bad_def
         $error("sctl_port: GAIN_DEF does not fit GAIN_W");
      end
      if (SYNC_STAGES < 1) begin : g_bad_sync
         $error("sctl_port: at least one synchronizer stage required");
      end
   endgenerate

   logic [2:0]                  link_s;
   logic                        frame_stb;
   logic [FRAME_BITS-1:0]       frame_word;
   logic [N_GAINS-1:0][GAIN_W-1:0]      codes;
   logic [N_GAINS-1:0][DB_W-1:0]        dbs;

   sctl_sync #(
      .W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b001)
   ) u_sync (
      .clk(clk), .rst_n(rst_n),
      .d({ser_en, ser_clk, ser_din}),
      .q(link_s)
   );

   sctl_frame_rx #(.FRAME_BITS(FRAME_BITS)) u_rx (
      .clk(clk), .rst_n(rst_n),
      .en_s(link_s[2]), .sclk_s(link_s[1]), .din_s(link_s[0]),
      .frame_stb(frame_stb), .frame_word(frame_word), .ack_q(ack_pull_low)
   );

   sctl_port_regs #(
      .FRAME_BITS(FRAME_BITS), .ADDR_LSB(ADDR_LSB), .ADDR_W(ADDR_W),
      .GAIN_W(GAIN_W), .GAIN_DEF(GAIN_DEF_V)
   ) u_regs (
      .clk(clk), .rst_n(rst_n),
      .frame_stb(frame_stb), .frame_word(frame_word), .corr_done(corr_done),
      .trk_gain(trk_gain), .foc_gain(foc_gain), .sleep(sleep), .corr_req(corr_req)
   );

   assign codes[0] = trk_gain;
   assign codes[1] = foc_gain;

   generate
      for (genvar g = 0; g < N_GAINS; g++) begin : g_map
         sctl_gain_map #(
            .GAIN_W(GAIN_W), .DB_W(DB_W), .DB_MAX(DB_MAX), .DB_STEP(DB_STEP)
         ) u_map (
            .code(codes[g]),
            .db(dbs[g])
         );
      end
   endgenerate

   assign trk_gain_db = dbs[0];
   assign foc_gain_db = dbs[1];

   AST_SLEEP_MASKS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      sleep |-> !corr_req); // R10
   AST_SLEEP_DEF_OUT: assert property (@(posedge clk) disable iff (!rst_n)
      sleep |-> (trk_gain == GAIN_DEF_V && foc_gain == GAIN_DEF_V)); // R9

endmodule

// File: tb/sctl_port_bench.sv
module sctl_port_bench;

   localparam int HALF = 6;
   localparam int SETTLE = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ser_en = 1'b0, ser_clk = 1'b0, ser_din = 1'b1, corr_done = 1'b0;
   logic ack_pull_low, sleep, corr_req;
   logic [3:0] trk_gain, foc_gain;
   logic signed [5:0] trk_gain_db, foc_gain_db;

   int checks = 0, failures = 0;
   bit done = 0;

   logic [3:0] m_trk = 4'd7, m_foc = 4'd7;
   logic m_sleep = 1'b0, m_corr = 1'b0;

   always #2 clk = ~clk;

   sctl_port u_sctl_port (
      .clk(clk), .rst_n(rst_n), .ser_en(ser_en), .ser_clk(ser_clk),
      .ser_din(ser_din), .corr_done(corr_done), .ack_pull_low(ack_pull_low),
      .trk_gain(trk_gain), .foc_gain(foc_gain), .sleep(sleep),
      .corr_req(corr_req), .trk_gain_db(trk_gain_db), .foc_gain_db(foc_gain_db)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic int db_of(input logic [3:0] c);
      return 14 - 2 * int'(c);
   endfunction

   function automatic logic [15:0] mk(input logic [4:0] addr, input logic [7:0] data,
                                      input logic [2:0] junk);
      return {data, junk[2], addr, junk[1:0]};
   endfunction

   task automatic model_apply(input logic [15:0] w, input int n);
      if (n < 16) return;
      if (w[6:2] == 5'd0 && !m_sleep) begin
         m_trk = w[15:12];
         m_foc = w[11:8];
      end else if (w[6:2] == 5'd1) begin
         m_sleep = w[15];
         m_corr  = w[14];
         if (m_sleep) begin
            m_trk = 4'd7;
            m_foc = 4'd7;
         end
      end
   endtask

   task automatic check_all(input string tag);
      logic [3:0] et, ef;
      et = m_sleep ? 4'd7 : m_trk;
      ef = m_sleep ? 4'd7 : m_foc;
      chk(trk_gain == et, {tag, " R6 trk"}, int'(trk_gain), int'(et));
      chk(foc_gain == ef, {tag, " R6 foc"}, int'(foc_gain), int'(ef));
      chk(sleep == m_sleep, {tag, " R7 sleep"}, int'(sleep), int'(m_sleep));
      chk(corr_req == (m_corr & ~m_sleep), {tag, " R10 corr_req"},
          int'(corr_req), int'(m_corr & ~m_sleep));
      chk(int'(trk_gain_db) == db_of(et), {tag, " R11 trk dB"}, int'(trk_gain_db), db_of(et));
      chk(int'(foc_gain_db) == db_of(ef), {tag, " R11 foc dB"}, int'(foc_gain_db), db_of(ef));
   endtask

   task automatic send(input logic [15:0] w, input int n, input string tag);
      @(negedge clk);
      ser_en = 1'b1;
      repeat (4) @(negedge clk);
      for (int i = 0; i < n; i++) begin
         ser_din = (i < 16) ? w[i] : logic'($urandom & 1);
         ser_clk = 1'b1;
         repeat (HALF) @(negedge clk);
         ser_clk = 1'b0;
         repeat (HALF) @(negedge clk);
         if (i == 14) chk(ack_pull_low == 1'b0, {tag, " R4 no early ack"}, int'(ack_pull_low), 0);
      end
      repeat (SETTLE) @(negedge clk);
      chk(ack_pull_low == (n >= 16), {tag, " R4 ack"}, int'(ack_pull_low), int'(n >= 16));
      model_apply(w, n);
      check_all(tag);
      ser_en = 1'b0;
      ser_din = 1'b1;
      repeat (SETTLE) @(negedge clk);
      chk(ack_pull_low == 1'b0, {tag, " R4 ack released"}, int'(ack_pull_low), 0);
   endtask

   task automatic pulse_done();
      @(negedge clk);
      corr_done = 1'b1;
      @(negedge clk);
      corr_done = 1'b0;
      m_trk = 4'd7; m_foc = 4'd7; m_sleep = 1'b0; m_corr = 1'b0;
      repeat (3) @(negedge clk);
      check_all("R8 restore");
   endtask

   initial begin
      void'($urandom(32'd2024));
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);
      chk(ack_pull_low == 1'b0, "R4 reset ack", int'(ack_pull_low), 0);
      check_all("reset R6 R7");

      // R1: asymmetric codes reveal bit order; R11 extremes
      send(mk(5'd0, 8'h0F, 3'b000), 16, "R1 trk0 foc15");
      send(mk(5'd0, 8'h81, 3'b111), 16, "R1 trk8 foc1");
      // R2 then R12: short frame, then clean full frame
      send(mk(5'd0, 8'h33, 3'b000), 15, "R2 short");
      send(mk(5'd0, 8'h5A, 3'b101), 16, "R12 after short");
      // R3: long frame
      send(mk(5'd0, 8'hC4, 3'b010), 21, "R3 long");
      // R5: unknown addresses
      send(mk(5'd16, 8'h00, 3'b000), 16, "R5 addr16");
      send(mk(5'd31, 8'hFF, 3'b111), 16, "R5 addr31");
      // R7 correction request
      send(mk(5'd1, 8'h40, 3'b000), 16, "R7 corr");
      // R9 R10: sleep with request
      send(mk(5'd1, 8'hC0, 3'b000), 16, "R10 sleep+corr");
      send(mk(5'd0, 8'h12, 3'b000), 16, "R9 write in sleep");
      send(mk(5'd1, 8'h00, 3'b000), 16, "R9 wake");
      send(mk(5'd0, 8'h9E, 3'b000), 16, "R9 write after wake");
      send(mk(5'd1, 8'h40, 3'b000), 16, "R7 corr again");
      pulse_done();

      for (int k = 0; k < 60; k++) begin
         int unsigned r;
         logic [4:0] a;
         int n;
         r = $urandom % 4;
         a = (r == 0) ? 5'd0 : (r == 1) ? 5'd1 : 5'(2 + ($urandom % 30));
         n = (($urandom % 3) == 0) ? int'(4 + ($urandom % 12)) : int'(16 + ($urandom % 5));
         send(mk(a, 8'($urandom), 3'($urandom)), n, "rand R1 R2 R3 R5");
         if (($urandom % 10) == 0) pulse_done();
      end

      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++;
         failures++;
         $display("FAIL watchdog expired actual=0 expected=1");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

endmodule